// File: doc/BRIEF.md
# Bit-Plane Readout Scanner

The block reads one binary plane held in a 64-row by 64-column array of bit-cells and streams it out as 16-bit words. A start request launches a scan that visits the rows in ascending order from row 0. For each row the scanner drives a 6-bit row address and a one-hot set of 64 row-enable lines for a single cycle. During that cycle the 64 read lines of the selected row are captured together into a row-wide latch. The scanner then spends four cycles steering the four 16-bit column groups of the latch to the output, lowest columns first.

The read lines are active-low. A stored one pulls its precharged line down, so the captured line level is inverted to recover the stored value. A full plane yields 256 valid words in 320 busy cycles. A one-cycle completion pulse follows the last word. A start request that arrives during a scan is ignored. A start request in the completion cycle opens the next scan immediately.

Top module: `plane_scanner`

## Requirements
- R1: After reset, busy_o, done_o and word_valid_o are 0 and all 64 row-enable lines are 0.
- R2: A start_i pulse while idle begins a scan at row 0, and busy_o stays 1 from the next cycle until the last word has been output.
- R3: In the one non-valid cycle that opens each row, row_en_o is one-hot with bit row_addr_o set. In every other cycle, row_en_o is all zero.
- R4: A read line sampled low (0) yields a 1 in the corresponding output bit, and a line sampled high yields a 0.
- R5: Each row is output as four consecutive valid words with col_sel_o = 0, 1, 2, 3. Word k carries columns 16k to 16k+15, and bit 0 of the word is column 16k.
- R6: Rows are output in ascending order 0 to 63, for exactly 256 valid words per scan.
- R7: Every row is preceded by exactly one busy cycle with word_valid_o low, so a scan has 64 such cycles.
- R8: done_o is 1 for exactly one cycle, which is the cycle after the last valid word. busy_o is 0 in that cycle.
- R9: start_i asserted while busy_o is 1 has no effect: the word stream and its length are unchanged.
- R10: start_i asserted in the cycle where done_o is 1 starts a new scan at row 0 with no further idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a plane scan (taken only when idle) |
| line_n_i | input | 64 | Active-low column read lines of the enabled row |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse after the last word |
| row_addr_o | output | 6 | Row currently being scanned |
| row_en_o | output | 64 | One-hot row-enable lines, active in the capture cycle |
| col_sel_o | output | 2 | Column group currently on the output |
| word_valid_o | output | 1 | word_data_o carries a column group |
| word_data_o | output | 16 | Recovered bits of the selected column group |

## Verification
The completion pulse of one scan and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising start_i exactly when it sees done_o. It changes the stored plane at the same moment. It then judges that the second stream begins at row 0 with the new contents, with the usual single row-opening cycle. A start pulse raised in the middle of a scan is also judged. The bench checks that such a pulse leaves the 256-word stream, its order and its 64 row-opening cycles unchanged.

// File: rtl/plane_scanner_pkg.sv
// Shared types for the bit-plane scanner.
package plane_scanner_pkg;
    // Scan sequencer states: idle, row capture, group output
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_LATCH = 2'd1,
        SC_EMIT  = 2'd2
    } scan_state_t;
endpackage

// File: rtl/row_line_decoder.sv
// Row-enable decoder: turns a binary row address into one-hot enable lines.
// Assumes addr is below LINES; all lines stay low while en is low.
module row_line_decoder #(
    parameter int LINES  = 64,
    parameter int ADDR_W = $clog2(LINES)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [LINES-1:0]  lines
);
    // One comparator per enable line
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = en && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/row_sense_latch.sv
// Row-wide sense latch: captures all active-low read lines of a row at once,
// stores the recovered (inverted) bits and steers one group to the output.
// Assumes sel is below the group count.
module row_sense_latch #(
    parameter int COLS   = 64,
    parameter int WORD_W = 16,
    parameter int GROUPS = COLS / WORD_W,
    parameter int SEL_W  = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [COLS-1:0]   line_n,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] word
);
    logic [COLS-1:0]   bits_q;
    logic [WORD_W-1:0] grp_words [GROUPS];

    // Capture the whole row; a pulled-down line is a stored one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (capture) begin
            bits_q <= ~line_n;
        end
    end

    // Slice the latch into column groups, lowest column at bit 0
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_words[g] = bits_q[g*WORD_W +: WORD_W];
    end

    // Column-group multiplexer
    assign word = grp_words[sel];

    // R4: output group after a capture equals the inverted sampled lines
    p_invert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture && sel == '0 |=> ((sel != '0) || (word == ~$past(line_n[WORD_W-1:0]))));
endmodule

// File: rtl/scan_sequencer.sv
// Scan sequencer: walks the rows upward from 0, spending one capture cycle
// and GROUPS output cycles on each row, then pulses done for one cycle.
// Assumes start is a level sampled each cycle; ignored unless idle.
module scan_sequencer
    import plane_scanner_pkg::*;
#(
    parameter int ROWS   = 64,
    parameter int GROUPS = 4,
    parameter int ROW_AW = $clog2(ROWS),
    parameter int GRP_W  = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ROW_AW-1:0] row,
    output logic [GRP_W-1:0]  grp,
    output logic              latch_en,
    output logic              valid,
    output logic              busy,
    output logic              done
);
    localparam logic [ROW_AW-1:0] ROW_LAST = ROW_AW'(ROWS - 1);
    localparam logic [GRP_W-1:0]  GRP_LAST = GRP_W'(GROUPS - 1);

    scan_state_t state_q;
    logic [ROW_AW-1:0] row_q;
    logic [GRP_W-1:0]  grp_q;
    logic              done_q;

    // State, row and group progression with the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            row_q   <= '0;
            grp_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SC_IDLE: begin
                    if (start) begin
                        state_q <= SC_LATCH;
                        row_q   <= '0;
                        grp_q   <= '0;
                    end
                end
                SC_LATCH: begin
                    state_q <= SC_EMIT;
                    grp_q   <= '0;
                end
                SC_EMIT: begin
                    if (grp_q == GRP_LAST) begin
                        grp_q <= '0;
                        if (row_q == ROW_LAST) begin
                            state_q <= SC_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            row_q   <= row_q + 1'b1;
                            state_q <= SC_LATCH;
                        end
                    end else begin
                        grp_q <= grp_q + 1'b1;
                    end
                end
                default: state_q <= SC_IDLE;
            endcase
        end
    end

    // Decode state into control outputs
    assign latch_en = (state_q == SC_LATCH);
    assign valid    = (state_q == SC_EMIT);
    assign busy     = (state_q != SC_IDLE);
    assign done     = done_q;
    assign row      = row_q;
    assign grp      = grp_q;

    // R8: completion is a single-cycle pulse and the block is idle then
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: a scan cannot be cut short or restarted before its last row
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && row != ROW_LAST |=> busy && row >= $past(row));
    // R5: groups step by one within a row
    p_group_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid && grp != GRP_LAST |=> valid && grp == $past(grp) + 1'b1);
    // R7: every capture cycle is followed by the first group of that row
    p_capture_then_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> valid && grp == '0 && row == $past(row));
endmodule

// File: rtl/plane_scanner.sv
// Bit-plane readout scanner top: sequences rows, drives one-hot row enables,
// captures each row's active-low read lines and outputs it as column groups.
// Assumes the array drives line_n_i combinationally from the enabled row.
module plane_scanner #(
    parameter int ROWS   = 64,
    parameter int COLS   = 64,
    parameter int WORD_W = 16,
    localparam int GROUPS = COLS / WORD_W,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int GRP_W  = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COLS-1:0]   line_n_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ROW_AW-1:0] row_addr_o,
    output logic [ROWS-1:0]   row_en_o,
    output logic [GRP_W-1:0]  col_sel_o,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_data_o
);
    logic latch_en;

    // Row and group sequencing
    scan_sequencer #(.ROWS(ROWS), .GROUPS(GROUPS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .row      (row_addr_o),
        .grp      (col_sel_o),
        .latch_en (latch_en),
        .valid    (word_valid_o),
        .busy     (busy_o),
        .done     (done_o)
    );

    // Row-enable line generation
    row_line_decoder #(.LINES(ROWS)) u_dec (
        .en    (latch_en),
        .addr  (row_addr_o),
        .lines (row_en_o)
    );

    // Row capture and column-group steering
    row_sense_latch #(.COLS(COLS), .WORD_W(WORD_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (latch_en),
        .line_n  (line_n_i),
        .sel     (col_sel_o),
        .word    (word_data_o)
    );

    // R3: enables are one-hot on the addressed row while not outputting
    p_row_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en_o != '0) |-> ($countones(row_en_o) == 1 && row_en_o[row_addr_o]
                              && !word_valid_o && busy_o));
    p_row_en_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o || !busy_o |-> row_en_o == '0);
    // R6: a new row starts only after the previous row's last group
    p_row_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) && row_addr_o != $past(row_addr_o)
        |-> row_addr_o == $past(row_addr_o) + 1'b1);
endmodule

// File: tb/test_plane_scanner.sv
// Bench for plane_scanner: a register bit-plane array model answers the
// row enables; the output stream is compared to expected words.
module test_plane_scanner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] line_n_i;
    logic        busy_o, done_o, word_valid_o;
    logic [5:0]  row_addr_o;
    logic [63:0] row_en_o;
    logic [1:0]  col_sel_o;
    logic [15:0] word_data_o;

    logic [63:0] plane [64];
    int checks = 0;
    int fails  = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    plane_scanner i_plane_scanner (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_n_i(line_n_i),
        .busy_o(busy_o), .done_o(done_o), .row_addr_o(row_addr_o),
        .row_en_o(row_en_o), .col_sel_o(col_sel_o),
        .word_valid_o(word_valid_o), .word_data_o(word_data_o)
    );

    // Array model: precharged high, a stored one pulls its line low
    always_comb begin
        line_n_i = '1;
        for (int r = 0; r < 64; r++)
            if (row_en_o[r]) line_n_i = ~plane[r];
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(int idx);
        return plane[idx / 4][(idx % 4) * 16 +: 16];
    endfunction

    task automatic fill(input int mode);
        for (int r = 0; r < 64; r++)
            case (mode)
                0: plane[r] = '0;
                1: plane[r] = '1;
                2: plane[r] = (r % 2) ? 64'hAAAA_AAAA_AAAA_AAAA : 64'h5555_5555_5555_5555;
                3: plane[r] = {32'h0, 26'h0, 6'(r)} | (64'h1 << r);
                default: plane[r] = {$urandom, $urandom};
            endcase
    endtask

    // One scan; mid_start pulses start during the scan, chain_mode>=0 restarts on done
    task automatic scan(input int mid_start, input int chain_mode, input string name,
                        output bit chained);
        int words = 0, gaps = 0, wrong = 0, cyc = 0;
        bit first_ok = 0;
        chained = 0;
        @(negedge clk);
        if (chain_mode < -1) start_i = 1'b0; else start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        first_ok = busy_o && row_addr_o == 6'd0 && row_en_o == 64'h1;
        check(first_ok, {"R2 scan begins at row 0 ", name}, row_en_o, 64'h1);
        forever begin
            if (word_valid_o) begin
                if (words < 256) begin
                    if (word_data_o !== exp_word(words) || row_addr_o !== 6'(words / 4)
                        || col_sel_o !== 2'(words % 4) || row_en_o != '0) begin
                        if (wrong == 0)
                            check(0, {"R4 R5 R6 word ", name}, word_data_o, exp_word(words));
                        wrong++;
                    end
                end
                words++;
            end else if (busy_o) begin
                gaps++;
                if (row_en_o !== (64'h1 << row_addr_o)) begin
                    if (wrong == 0) check(0, {"R3 row enable ", name}, row_en_o, 64'h1 << row_addr_o);
                    wrong++;
                end
            end
            if (done_o) break;
            cyc++;
            if (cyc == mid_start) start_i = 1'b1;
            if (cyc == mid_start + 1) start_i = 1'b0;
            @(negedge clk);
        end
        check(wrong == 0, {"R4 R5 all words match ", name}, wrong, 0);
        check(words == 256, {"R6 word count ", name}, words, 256);
        check(gaps == 64, {"R7 row opening cycles ", name}, gaps, 64);
        check(!busy_o, {"R8 idle during done ", name}, busy_o, 0);
        if (chain_mode >= 0) begin
            fill(chain_mode);
            start_i = 1'b1;
            chained = 1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o && row_en_o == 64'h1, {"R10 restart in done cycle ", name}, row_en_o, 64'h1);
            @(negedge clk);
        end else begin
            @(negedge clk);
            check(!done_o, {"R8 done lasts one cycle ", name}, done_o, 0);
        end
    endtask

    // Continue a chained scan already started: rerun collection without a new start
    task automatic follow(input string name);
        int words = 1, wrong = 0;
        if (!(word_valid_o && word_data_o === exp_word(0))) wrong++;
        forever begin
            @(negedge clk);
            if (done_o) break;
            if (word_valid_o) begin
                if (word_data_o !== exp_word(words)) wrong++;
                words++;
            end
        end
        check(wrong == 0 && words == 256, {"R10 chained stream ", name}, words, 256);
        @(negedge clk);
    endtask

    initial begin
        bit ch;
        void'($urandom(32'h5EED_0042));
        fill(0);
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !word_valid_o && row_en_o == '0,
              "R1 reset state", {busy_o, done_o, word_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && row_en_o == '0, "R1 idle after reset", row_en_o, 0);

        fill(0); scan(-5, -1, "zeros", ch);
        fill(1); scan(-5, -1, "ones", ch);
        fill(2); scan(-5, -1, "checker", ch);
        fill(3); scan(-5, -1, "diagonal", ch);
        fill(4); scan(37, -1, "random with start mid scan R9", ch);
        fill(4); scan(300, -1, "random with late start R9", ch);
        fill(4); scan(-5, 4, "random then chained", ch);
        follow("chained random");
        fill(2); scan(-5, -1, "after chain", ch);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
        checks++;
        fails++;
        $display("FAIL watchdog expired R2 actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule